// File: doc/BRIEF.md
# CAN FD Transmit Format Selector

This block decides, once per outgoing frame, which wire format a queued transmit element uses. There are three formats: classic, flexible-data-rate without a bit-rate change, and flexible-data-rate with the faster data-phase bit rate. It also fixes the value of the error-status-indicator bit carried by flexible-data-rate frames. Two node-level configuration bits decide how far the element's own format-request bits are honoured. The first enables flexible-data-rate operation and the second enables bit-rate switching. Both configuration bits sit behind a write guard and change only while the controller is in initialization with configuration changes unlocked.

When the transmit-start strobe arrives, the selector resolves the format from the configuration, the element's two request bits and the node's error-passive flag. It latches the result and holds it steady for the serializer until the frame-end strobe. Signal levels follow bus convention: 0 is dominant and 1 is recessive.

The control is a two-state machine. `ST_IDLE` waits for a frame. The transition *launch* (`ST_IDLE` to `ST_SEND`, on `tx_start`) captures the resolved bits. `ST_SEND` holds them. The transition *finish* (`ST_SEND` to `ST_IDLE`, on `tx_done`) frees the selector for the next frame. The latched bits stay on the outputs until the next launch. The resolved format is one of `FMT_CLASSIC`, `FMT_FD_FIXED` or `FMT_FD_SWITCH`.

Top module: `fdtx_fmt_sel`

## Requirements
- R1: After reset, `cfg_fd_en`, `cfg_rate_sw_en`, `frm_busy`, `frm_fdf`, `frm_brs` and `frm_esi` are all 0.
- R2: A configuration write (`cfg_wr_en`=1) while `init_mode`=1 and `cfg_change_en`=1 loads `cfg_wr_fd_en` and `cfg_wr_rate_sw_en`, and the new values appear on `cfg_fd_en`/`cfg_rate_sw_en` one cycle later.
- R3: A configuration write while `init_mode` or `cfg_change_en` is 0 is dropped, and both configuration outputs keep their previous values.
- R4: With `cfg_fd_en`=0, a launched frame has `frm_fdf`=0 and `frm_brs`=0 regardless of `elem_fdf`/`elem_brs`.
- R5: With `cfg_fd_en`=1 and `cfg_rate_sw_en`=0, `frm_fdf` equals `elem_fdf` and `frm_brs` is 0.
- R6: With both configuration bits 1, a frame with `elem_fdf`=1 and `elem_brs`=1 is sent with `frm_fdf`=1 and `frm_brs`=1. `frm_brs` is never 1 while `frm_fdf` is 0.
- R7: An element with `elem_fdf`=0 is always sent as classic (`frm_fdf`=0, `frm_brs`=0, `frm_esi`=0) under any configuration.
- R8: For a flexible-data-rate frame, `frm_esi` is the value of `node_err_passive` at launch: 1 (recessive) if error passive, otherwise 0 (dominant).
- R9: `tx_start` in `ST_IDLE` sets `frm_busy` and the latched bits on the next clock edge.
- R10: While `frm_busy`=1, `frm_fdf`, `frm_brs` and `frm_esi` do not change, whatever happens on the element bits, `node_err_passive`, `tx_start` or the configuration.
- R11: `tx_done` while busy clears `frm_busy` on the next edge, and the latched bits keep their values.
- R12: `tx_done` while idle has no effect: `frm_busy` stays 0 and the latched bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_fd_en | input | 1 | Write data for the FD-enable bit |
| cfg_wr_rate_sw_en | input | 1 | Write data for the rate-switch-enable bit |
| init_mode | input | 1 | Controller is in initialization |
| cfg_change_en | input | 1 | Configuration changes unlocked |
| cfg_fd_en | output | 1 | Current FD-enable bit |
| cfg_rate_sw_en | output | 1 | Current rate-switch-enable bit |
| elem_fdf | input | 1 | Element requests FD format |
| elem_brs | input | 1 | Element requests bit-rate switching |
| node_err_passive | input | 1 | Node is error passive |
| tx_start | input | 1 | Frame transmission starts |
| tx_done | input | 1 | Frame transmission ends |
| frm_busy | output | 1 | A frame is in progress |
| frm_fdf | output | 1 | Latched effective FD format bit |
| frm_brs | output | 1 | Latched effective bit-rate-switch bit |
| frm_esi | output | 1 | Latched error-status-indicator bit |

## Verification
A wrong state in the machine shows up at once on `frm_busy`. A launch that is missed or doubled, or a finish that is lost, changes that flag on the cycle after the strobe. A stale or corrupted capture register shows up on the frame bits on the first cycle of the frame, or as a change in the middle of a frame when the element inputs are moved. A guard that leaks writes changes `cfg_fd_en` or `cfg_rate_sw_en` one cycle after the blocked strobe, and the next frame's format then also differs from the expected one.

// File: rtl/fdtx_pkg.sv
package fdtx_pkg;

    localparam logic BIT_DOM = 1'b0;
    localparam logic BIT_REC = 1'b1;

    typedef enum logic [1:0] {
        FMT_CLASSIC   = 2'd0,
        FMT_FD_FIXED  = 2'd1,
        FMT_FD_SWITCH = 2'd2
    } tx_fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } frm_state_e;

    typedef struct packed {
        logic fdf;
        logic brs;
        logic esi;
    } frm_bits_t;

    localparam frm_bits_t FRM_BITS_RESET = '{fdf: 1'b0, brs: 1'b0, esi: BIT_DOM};

endpackage

// File: rtl/fdtx_cfg_guard.sv
module fdtx_cfg_guard #(
    parameter bit RST_FD_EN      = 1'b0,
    parameter bit RST_RATE_SW_EN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_fd_en,
    input  logic wr_rate_sw_en,
    input  logic init_mode,
    input  logic cfg_change_en,
    output logic fd_en_q,
    output logic rate_sw_en_q
);

    logic unlocked;
    logic wr_accept;

    assign unlocked  = init_mode & cfg_change_en;
    assign wr_accept = wr_en & unlocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fd_en_q      <= RST_FD_EN;
            rate_sw_en_q <= RST_RATE_SW_EN;
        end else if (wr_accept) begin
            fd_en_q      <= wr_fd_en;
            rate_sw_en_q <= wr_rate_sw_en;
        end
    end

    // R2: an unlocked write lands one cycle later
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && init_mode && cfg_change_en) |=>
            (fd_en_q == $past(wr_fd_en)) && (rate_sw_en_q == $past(wr_rate_sw_en)));

    // R3: a locked write leaves both bits untouched
    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(init_mode && cfg_change_en)) |=>
            ($stable(fd_en_q) && $stable(rate_sw_en_q)));

endmodule

// File: rtl/fdtx_fmt_resolve.sv
module fdtx_fmt_resolve
    import fdtx_pkg::*;
(
    input  logic      fd_en,
    input  logic      rate_sw_en,
    input  logic      elem_fdf,
    input  logic      elem_brs,
    input  logic      err_passive,
    output tx_fmt_e   fmt,
    output frm_bits_t bits
);

    // format choice: configuration gates the element's requests
    always_comb begin
        unique case ({fd_en, rate_sw_en})
            2'b00, 2'b01: fmt = FMT_CLASSIC;
            2'b10:        fmt = elem_fdf ? FMT_FD_FIXED : FMT_CLASSIC;
            2'b11: begin
                if (!elem_fdf)     fmt = FMT_CLASSIC;
                else if (elem_brs) fmt = FMT_FD_SWITCH;
                else               fmt = FMT_FD_FIXED;
            end
            default:      fmt = FMT_CLASSIC;
        endcase
    end

    // wire bits for each format; ESI only meaningful in FD frames
    always_comb begin
        unique case (fmt)
            FMT_FD_FIXED: begin
                bits.fdf = 1'b1;
                bits.brs = 1'b0;
                bits.esi = err_passive ? BIT_REC : BIT_DOM;
            end
            FMT_FD_SWITCH: begin
                bits.fdf = 1'b1;
                bits.brs = 1'b1;
                bits.esi = err_passive ? BIT_REC : BIT_DOM;
            end
            default: begin
                bits.fdf = 1'b0;
                bits.brs = 1'b0;
                bits.esi = BIT_DOM;
            end
        endcase
    end

endmodule

// File: rtl/fdtx_frame_fsm.sv
module fdtx_frame_fsm
    import fdtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_start,
    input  logic       tx_done,
    input  frm_bits_t  cand,
    output frm_state_e state,
    output frm_bits_t  held
);

    frm_state_e state_nx;
    logic       launch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: launch and finish
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (tx_start) state_nx = ST_SEND;
            ST_SEND: if (tx_done)  state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    assign launch = (state == ST_IDLE) && tx_start;

    // outputs: capture on launch, hold otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held <= FRM_BITS_RESET;
        else if (launch) held <= cand;
    end

    // R10: bits frozen while a frame keeps running
    assert_hold_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !tx_done) |=> (state == ST_SEND) && $stable(held));

    // R11: finish returns to idle and keeps the bits
    assert_finish_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && tx_done) |=> (state == ST_IDLE) && $stable(held));

    // R12: idle without a start stays idle and unchanged
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !tx_start) |=> (state == ST_IDLE) && $stable(held));

    // R9: launch takes the candidate
    assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tx_start) |=> (state == ST_SEND) && (held == $past(cand)));

endmodule

// File: rtl/fdtx_fmt_sel.sv
module fdtx_fmt_sel
    import fdtx_pkg::*;
#(
    parameter bit RST_FD_EN      = 1'b0,
    parameter bit RST_RATE_SW_EN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr_en,
    input  logic cfg_wr_fd_en,
    input  logic cfg_wr_rate_sw_en,
    input  logic init_mode,
    input  logic cfg_change_en,
    output logic cfg_fd_en,
    output logic cfg_rate_sw_en,
    input  logic elem_fdf,
    input  logic elem_brs,
    input  logic node_err_passive,
    input  logic tx_start,
    input  logic tx_done,
    output logic frm_busy,
    output logic frm_fdf,
    output logic frm_brs,
    output logic frm_esi
);

    tx_fmt_e    fmt;
    frm_bits_t  cand;
    frm_bits_t  held;
    frm_state_e state;

    fdtx_cfg_guard #(
        .RST_FD_EN      (RST_FD_EN),
        .RST_RATE_SW_EN (RST_RATE_SW_EN)
    ) u_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (cfg_wr_en),
        .wr_fd_en      (cfg_wr_fd_en),
        .wr_rate_sw_en (cfg_wr_rate_sw_en),
        .init_mode     (init_mode),
        .cfg_change_en (cfg_change_en),
        .fd_en_q       (cfg_fd_en),
        .rate_sw_en_q  (cfg_rate_sw_en)
    );

    fdtx_fmt_resolve u_resolve (
        .fd_en       (cfg_fd_en),
        .rate_sw_en  (cfg_rate_sw_en),
        .elem_fdf    (elem_fdf),
        .elem_brs    (elem_brs),
        .err_passive (node_err_passive),
        .fmt         (fmt),
        .bits        (cand)
    );

    fdtx_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_start (tx_start),
        .tx_done  (tx_done),
        .cand     (cand),
        .state    (state),
        .held     (held)
    );

    assign frm_busy = (state == ST_SEND);
    assign frm_fdf  = held.fdf;
    assign frm_brs  = held.brs;
    assign frm_esi  = held.esi;

    // R4: FD disabled at launch means a classic frame
    assert_fd_off_classic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_busy && tx_start && !cfg_fd_en) |=> (!frm_fdf && !frm_brs));

    // R6: switching only inside an FD frame
    assert_brs_needs_fdf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_brs |-> frm_fdf);

    // R7: element without FD request is always classic
    assert_classic_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_busy && tx_start && !elem_fdf) |=> (!frm_fdf && !frm_brs && !frm_esi));

    // R8: ESI of an FD frame follows error-passive at launch
    assert_esi_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_busy && tx_start && cfg_fd_en && elem_fdf) |=>
            (frm_esi == $past(node_err_passive)));

endmodule

// File: tb/fdtx_fmt_sel_test.sv
module fdtx_fmt_sel_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0, cfg_wr_fd_en = 1'b0, cfg_wr_rate_sw_en = 1'b0;
    logic init_mode = 1'b0, cfg_change_en = 1'b0;
    logic elem_fdf = 1'b0, elem_brs = 1'b0, node_err_passive = 1'b0;
    logic tx_start = 1'b0, tx_done = 1'b0;
    logic cfg_fd_en, cfg_rate_sw_en, frm_busy, frm_fdf, frm_brs, frm_esi;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    fdtx_fmt_sel uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_fd_en(cfg_wr_fd_en),
        .cfg_wr_rate_sw_en(cfg_wr_rate_sw_en),
        .init_mode(init_mode), .cfg_change_en(cfg_change_en),
        .cfg_fd_en(cfg_fd_en), .cfg_rate_sw_en(cfg_rate_sw_en),
        .elem_fdf(elem_fdf), .elem_brs(elem_brs),
        .node_err_passive(node_err_passive),
        .tx_start(tx_start), .tx_done(tx_done),
        .frm_busy(frm_busy), .frm_fdf(frm_fdf), .frm_brs(frm_brs), .frm_esi(frm_esi)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] frm_vec();
        return {frm_busy, frm_fdf, frm_brs, frm_esi};
    endfunction

    function automatic logic [3:0] cfg_vec();
        return {2'b00, cfg_fd_en, cfg_rate_sw_en};
    endfunction

    task automatic cfg_write(input logic fd, input logic sw, input logic ini, input logic cce);
        @(negedge clk);
        cfg_wr_fd_en = fd; cfg_wr_rate_sw_en = sw;
        init_mode = ini; cfg_change_en = cce; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0; init_mode = 1'b0; cfg_change_en = 1'b0;
    endtask

    // launch, check captured bits, finish, check bits kept
    task automatic send(input string req, input logic f, input logic b, input logic ep,
                        input logic xf, input logic xb, input logic xe);
        @(negedge clk);
        elem_fdf = f; elem_brs = b; node_err_passive = ep; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk({req, " launch (R9)"}, frm_vec(), {1'b1, xf, xb, xe});
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk({req, " finish (R11)"}, frm_vec(), {1'b0, xf, xb, xe});
    endtask

    task automatic t_reset();
        chk("R1 config", cfg_vec(), 4'b0000);
        chk("R1 frame", frm_vec(), 4'b0000);
    endtask

    task automatic t_cfg_guard();
        cfg_write(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R2 unlocked write", cfg_vec(), 4'b0011);
        cfg_write(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R3 init only", cfg_vec(), 4'b0011);
        cfg_write(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 change-enable only", cfg_vec(), 4'b0011);
        cfg_write(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 fully locked", cfg_vec(), 4'b0011);
        cfg_write(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R2 second write", cfg_vec(), 4'b0010);
    endtask

    task automatic t_fd_off();
        cfg_write(1'b0, 1'b1, 1'b1, 1'b1);
        send("R4 fd off, fdf+brs", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send("R7 fd off, classic req", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_fd_nosw();
        cfg_write(1'b1, 1'b0, 1'b1, 1'b1);
        send("R5 fdf+brs no switch", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        send("R8 passive esi", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        send("R7 classic with fd on", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_fd_sw();
        cfg_write(1'b1, 1'b1, 1'b1, 1'b1);
        send("R6 switch active", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        send("R8 switch passive", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        send("R6 fdf without brs", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        send("R7 brs without fdf", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        cfg_write(1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        elem_fdf = 1'b1; elem_brs = 1'b1; node_err_passive = 1'b0; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk("R9 hold launch", frm_vec(), 4'b1110);
        elem_fdf = 1'b0; elem_brs = 1'b0; node_err_passive = 1'b1; tx_start = 1'b1;
        cfg_wr_fd_en = 1'b0; cfg_wr_rate_sw_en = 1'b0;
        init_mode = 1'b1; cfg_change_en = 1'b1; cfg_wr_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 frozen in frame", frm_vec(), 4'b1110);
        end
        cfg_wr_en = 1'b0; init_mode = 1'b0; cfg_change_en = 1'b0; tx_start = 1'b0;
        chk("R2 write during frame", cfg_vec(), 4'b0000);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk("R11 after hold", frm_vec(), 4'b0110);
    endtask

    task automatic t_done_idle();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        chk("R12 stray finish 1", frm_vec(), 4'b0110);
        @(negedge clk);
        tx_done = 1'b0;
        chk("R12 stray finish 2", frm_vec(), 4'b0110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_guard();
        t_fd_off();
        t_fd_nosw();
        t_fd_sw();
        t_hold();
        t_done_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule